// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test access port in the style of IEEE 1149.1. The test clock, mode-select and data-in pins steer a sixteen-state controller. An active-low asynchronous reset also returns the port to its idle reset state. A serial data-out pin, qualified by an output enable, returns whichever register the current instruction places between data-in and data-out.

The instruction register is two bits wide and decodes exactly four instructions. The first returns a fixed 32-bit identification word. The second is a one-bit bypass. The last two, a sample/preload and an external-test instruction, share a small parallel-load boundary chain. That chain captures a pin vector and loads its shifted contents into an update register. The update register is visible at the ports. The external-test instruction also raises a drive flag that tells surrounding I/O cells to take their values from the update register.

Top module: `scan_tap`

## Requirements
- R1: While `rst_ni` is low the controller is in Test-Logic-Reset, the instruction is IDCODE (code 10), `tdo_oe_o` and `tdo_o` are 0 and `bnd_out_o` is 0; after release the first data scan returns the identification word.
- R2: Five rising TCK edges with `tms_i` high bring the controller to Test-Logic-Reset from any state, with IDCODE selected.
- R3: The state advances on each rising edge of `tck_i` along the standard sixteen-state graph, including the Pause and Exit2 loops, and shifting resumes without losing data after a pause.
- R4: `tdo_o` changes only on the falling edge of `tck_i`; `tdo_oe_o` is 1 only in Shift-DR and Shift-IR, and `tdo_o` is 0 whenever `tdo_oe_o` is 0. All registers shift least significant bit first, with `tdi_i` entering at the most significant end.
- R5: In Capture-IR the instruction shift register loads 01, so the first bit shifted out is 1 and the second is 0.
- R6: The shifted instruction takes effect on the falling edge in Update-IR, with codes 00 external test, 01 sample/preload, 10 IDCODE, 11 bypass (bit 0 shifted in first).
- R7: Under IDCODE, Capture-DR loads the 32-bit word 0x027801CB: version 0000 in bits 31..28, part number 0x2780 in bits 27..12, manufacturer code 0x0E5 in bits 11..1 and bit 0 equal to 1.
- R8: Under bypass, Capture-DR loads 0 into a one-bit register, so the data-out stream is 0 followed by `tdi_i` delayed by one TCK.
- R9: Under sample/preload and external test, Capture-DR loads `bnd_pins_i` (bit 0 leaves first), and the falling edge in Update-DR copies the chain into `bnd_out_o`; an Update-DR under IDCODE or bypass leaves `bnd_out_o` unchanged.
- R10: `ext_drive_o` is 1 exactly while the external test instruction (00) is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous port reset |
| tms_i | input | 1 | Mode select, sampled on rising TCK |
| tdi_i | input | 1 | Serial data in, sampled on rising TCK |
| tdo_o | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe_o | output | 1 | Output enable for `tdo_o` |
| bnd_pins_i | input | BND_W | Pin values captured by the boundary chain |
| bnd_out_o | output | BND_W | Boundary update register |
| ext_drive_o | output | 1 | High while external test is in effect |

## Verification
A state change, a capture and a shift all happen on a rising TCK edge. The first bit of a newly captured register, and each following shifted bit, reaches `tdo_o` at the next falling edge. Instruction changes, `bnd_out_o` and `ext_drive_o` follow on the falling edge inside Update-IR or Update-DR. The bench drives `tms_i` and `tdi_i` just after a falling edge and samples every output one nanosecond after the next falling edge. Each serial bit is therefore read half a TCK after the rising edge that produced it, and each update result is read in the Run-Test/Idle step that follows.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int unsigned IR_W = 2;
  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_IDCODE = 2'b10,
    OP_BYPASS = 2'b11
  } tap_op_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_RTI;
      ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      default:   return tms ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

  // consecutive TMS-high counter, checker use only
  localparam int unsigned RESET_RUN = 5;
  logic [2:0] hi_cnt_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   hi_cnt_q <= '0;
    else if (!tms_i)               hi_cnt_q <= '0;
    else if (hi_cnt_q != 3'(RESET_RUN)) hi_cnt_q <= hi_cnt_q + 3'd1;
  end

  a_r2_five_tms_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hi_cnt_q == 3'(RESET_RUN) |-> state_q == ST_TLR);

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output tap_op_e    op_o,
  output logic       sr_lsb_o
);

  logic [IR_W-1:0] sr_q;
  tap_op_e         op_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   sr_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // instruction changes on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   op_q <= OP_IDCODE;
    else if (state_i == ST_TLR)    op_q <= OP_IDCODE;
    else if (state_i == ST_UPD_IR) op_q <= tap_op_e'(sr_q);
  end

  assign op_o     = op_q;
  assign sr_lsb_o = sr_q[0];

  a_r5_capture_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sr_q == IR_CAPTURE);

  a_r1_tlr_holds_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |-> op_q == OP_IDCODE);

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int unsigned BND_W   = 8,
  parameter int unsigned ID_W    = 32,
  parameter logic [ID_W-1:0] ID_WORD = 32'h0278_01CB
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  tap_state_e       state_i,
  input  tap_op_e          op_i,
  input  logic [BND_W-1:0] bnd_pins_i,
  output logic [BND_W-1:0] bnd_out_o,
  output logic             dr_lsb_o
);

  logic cap, sft;
  assign cap = (state_i == ST_CAP_DR);
  assign sft = (state_i == ST_SH_DR);

  logic sel_bnd, sel_id, sel_byp;
  assign sel_bnd = (op_i == OP_EXTEST) || (op_i == OP_SAMPLE);
  assign sel_id  = (op_i == OP_IDCODE);
  assign sel_byp = (op_i == OP_BYPASS);

  // bypass
  logic byp_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)              byp_q <= 1'b0;
    else if (sel_byp && cap)  byp_q <= 1'b0;
    else if (sel_byp && sft)  byp_q <= tdi_i;
  end

  // identification
  logic [ID_W-1:0] id_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)            id_q <= ID_WORD;
    else if (sel_id && cap) id_q <= ID_WORD;
    else if (sel_id && sft) id_q <= {tdi_i, id_q[ID_W-1:1]};
  end

  // boundary chain
  logic [BND_W-1:0] chain_q, chain_d, upd_q;
  for (genvar g = 0; g < BND_W; g++) begin : g_cell
    logic shin;
    if (g == BND_W - 1) begin : g_top
      assign shin = tdi_i;
    end else begin : g_mid
      assign shin = chain_q[g+1];
    end
    always_comb begin
      chain_d[g] = chain_q[g];
      if (cap)      chain_d[g] = bnd_pins_i[g];
      else if (sft) chain_d[g] = shin;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (sel_bnd) chain_q <= chain_d;
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                             upd_q <= '0;
    else if (sel_bnd && state_i == ST_UPD_DR) upd_q <= chain_q;
  end

  assign bnd_out_o = upd_q;

  always_comb begin
    case (op_i)
      OP_BYPASS: dr_lsb_o = byp_q;
      OP_IDCODE: dr_lsb_o = id_q[0];
      default:   dr_lsb_o = chain_q[0];
    endcase
  end

  a_r8_bypass_zero: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_byp) |=> !byp_q);

  a_r7_id_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_id) |=> id_q == ID_WORD);

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int unsigned BND_W   = 8,
  parameter logic [31:0] ID_WORD = 32'h0278_01CB
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             tdo_oe_o,
  input  logic [BND_W-1:0] bnd_pins_i,
  output logic [BND_W-1:0] bnd_out_o,
  output logic             ext_drive_o
);

  tap_state_e state;
  tap_op_e    op;
  logic       ir_lsb, dr_lsb;

  scan_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  scan_tap_ir u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state),
    .op_o     (op),
    .sr_lsb_o (ir_lsb)
  );

  scan_tap_dr #(
    .BND_W   (BND_W),
    .ID_W    (32),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .tdi_i      (tdi_i),
    .state_i    (state),
    .op_i       (op),
    .bnd_pins_i (bnd_pins_i),
    .bnd_out_o  (bnd_out_o),
    .dr_lsb_o   (dr_lsb)
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_SH_IR: begin tdo_o <= ir_lsb; tdo_oe_o <= 1'b1; end
        ST_SH_DR: begin tdo_o <= dr_lsb; tdo_oe_o <= 1'b1; end
        default:  begin tdo_o <= 1'b0;   tdo_oe_o <= 1'b0; end
      endcase
    end
  end

  assign ext_drive_o = (op == OP_EXTEST);

  a_r4_oe_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state == ST_SH_DR || state == ST_SH_IR));

  a_r4_quiet_tdo: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_oe_o |-> !tdo_o);

  a_r10_drive_flag: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ext_drive_o |-> op == OP_EXTEST);

endmodule

// File: tb/scan_tap_test.sv
module scan_tap_test;

  localparam int BND_W = 8;
  localparam logic [31:0] EXP_ID = {4'b0000, 16'b0010_0111_1000_0000, 11'b000_1110_0101, 1'b1};

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tms_i = 1'b1;
  logic tdi_i = 1'b0;
  logic tdo_o, tdo_oe_o, ext_drive_o;
  logic [BND_W-1:0] bnd_pins_i = '0;
  logic [BND_W-1:0] bnd_out_o;

  int checks = 0;
  int errors = 0;

  always #2 tck = ~tck;

  scan_tap #(.BND_W(BND_W)) uut (
    .tck_i       (tck),
    .rst_ni      (rst_ni),
    .tms_i       (tms_i),
    .tdi_i       (tdi_i),
    .tdo_o       (tdo_o),
    .tdo_oe_o    (tdo_oe_o),
    .bnd_pins_i  (bnd_pins_i),
    .bnd_out_o   (bnd_out_o),
    .ext_drive_o (ext_drive_o)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] byp_expect(input int n, input logic [63:0] din);
    return (din << 1) & ((64'd1 << n) - 64'd1);
  endfunction

  // call at falling edge + 1; returns at next falling edge + 1
  task automatic step(input logic tms, input logic tdi);
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [1:0] op, output logic [1:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo_o;
    step(0, op[0]);
    cap[1] = tdo_o;
    step(1, op[1]);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] dout, din;
    logic [1:0] cap;
    logic [BND_W-1:0] pins, held;
    void'($urandom(32'h5eed_0001));

    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    check({63'd0, tdo_oe_o}, 64'd0, "R1 oe in reset");
    check({63'd0, tdo_o}, 64'd0, "R1 tdo in reset");
    check({56'd0, bnd_out_o}, 64'd0, "R1 bnd_out in reset");
    check({63'd0, ext_drive_o}, 64'd0, "R10 drive after reset");
    rst_ni = 1'b1;
    step(1, 0);
    step(0, 0);
    check({63'd0, tdo_oe_o}, 64'd0, "R4 oe in idle");

    scan_dr(32, 64'd0, dout);
    check(dout, {32'd0, EXP_ID}, "R1 R7 id after reset");

    load_ir(2'b11, cap);
    check({62'd0, cap}, 64'd1, "R5 capture-ir pattern");
    check({63'd0, ext_drive_o}, 64'd0, "R10 drive under bypass");
    for (int k = 0; k < 6; k++) begin
      int n;
      n = 4 + int'($urandom_range(0, 40));
      din = {$urandom, $urandom};
      scan_dr(n, din, dout);
      check(dout, byp_expect(n, din), "R8 bypass delay");
    end

    // pause loop inside Shift-DR under bypass
    step(1, 0); step(0, 0); step(0, 0);
    check({63'd0, tdo_oe_o}, 64'd1, "R4 oe in shift-dr");
    check({63'd0, tdo_o}, 64'd0, "R8 bypass capture 0");
    step(0, 1); step(0, 0); step(1, 1);
    step(0, 0); step(0, 0);
    check({63'd0, tdo_oe_o}, 64'd0, "R3 R4 oe in pause-dr");
    check({63'd0, tdo_o}, 64'd0, "R4 tdo quiet in pause");
    step(1, 0); step(0, 0);
    check({63'd0, tdo_oe_o}, 64'd1, "R3 back in shift-dr");
    check({63'd0, tdo_o}, 64'd1, "R3 data kept over pause");
    step(1, 0); step(1, 0); step(0, 0);

    load_ir(2'b01, cap);
    check({62'd0, cap}, 64'd1, "R5 capture-ir again");
    check({63'd0, ext_drive_o}, 64'd0, "R10 drive under sample");
    for (int k = 0; k < 4; k++) begin
      pins = BND_W'($urandom);
      bnd_pins_i = pins;
      din = {56'd0, 8'($urandom)};
      scan_dr(BND_W, din, dout);
      check(dout, {56'd0, pins}, "R9 sample capture");
      check({56'd0, bnd_out_o}, din, "R9 sample update");
    end
    held = bnd_out_o;

    load_ir(2'b00, cap);
    check({63'd0, ext_drive_o}, 64'd1, "R6 R10 extest drive");
    check({56'd0, bnd_out_o}, {56'd0, held}, "R9 preload kept");
    pins = 8'hA5;
    bnd_pins_i = pins;
    din = 64'h3C;
    scan_dr(BND_W, din, dout);
    check(dout, {56'd0, pins}, "R9 extest capture");
    check({56'd0, bnd_out_o}, 64'h3C, "R9 extest update");

    load_ir(2'b11, cap);
    check({63'd0, ext_drive_o}, 64'd0, "R10 drive dropped");
    scan_dr(BND_W, 64'hFF, dout);
    check({56'd0, bnd_out_o}, 64'h3C, "R9 bypass leaves update");

    load_ir(2'b10, cap);
    scan_dr(32, 64'd0, dout);
    check(dout, {32'd0, EXP_ID}, "R6 R7 idcode instruction");
    scan_dr(BND_W, 64'h0, dout);
    check({56'd0, bnd_out_o}, 64'h3C, "R9 idcode leaves update");

    // five TMS-high from inside Shift-DR under extest
    load_ir(2'b00, cap);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    for (int k = 0; k < 5; k++) step(1, 0);
    check({63'd0, ext_drive_o}, 64'd0, "R2 tms reset drops extest");
    step(0, 0);
    scan_dr(32, 64'd0, dout);
    check(dout, {32'd0, EXP_ID}, "R2 idcode after tms reset");

    // five TMS-high from Shift-IR
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check({63'd0, tdo_oe_o}, 64'd1, "R4 oe in shift-ir");
    for (int k = 0; k < 5; k++) step(1, 0);
    step(0, 0);
    scan_dr(32, 64'd0, dout);
    check(dout, {32'd0, EXP_ID}, "R2 from shift-ir");

    // asynchronous reset mid-run
    load_ir(2'b00, cap);
    check({63'd0, ext_drive_o}, 64'd1, "R10 extest before reset");
    rst_ni = 1'b0;
    #1;
    check({63'd0, ext_drive_o}, 64'd0, "R1 async reset clears extest");
    check({56'd0, bnd_out_o}, 64'd0, "R1 async reset clears update");
    @(negedge tck); #1;
    rst_ni = 1'b1;
    step(0, 0);
    scan_dr(32, 64'd0, dout);
    check(dout, {32'd0, EXP_ID}, "R1 idcode after async reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule